// File: doc/BRIEF.md
# Message Time Tag Counter

This block keeps a free-running 16-bit real-time count for a serial bus message engine. A 1 MHz reference pulse drives a prescaler, and the prescaler sets the time per count step to 2, 4, 8, 16, 32 or 64 µs, chosen by a 3-bit select. The live count is always visible on an output port.

Two snapshot channels record the count when a message starts and when it ends. Each channel holds its stamp and raises a one-cycle valid pulse, so that a descriptor-stack writer can store the value. The host can clear the count or load it. A load can also keep the counter's current least significant bit and take only the upper bits from the host.

Top module: `mtt_timetag`

## Requirements
- R1: With select code s in 0..5, the count advances by exactly one for every 2^(s+1) reference pulses. Codes 6 and 7 behave like code 5 (64 pulses per step). The count never advances on two consecutive clocks.
- R2: The count is 16 bits wide and wraps from 0xFFFF to 0x0000 on the next step.
- R3: In any clock where the select differs from its value in the previous clock, the prescaler restarts from zero and the count does not advance. The next step then needs a full new period of reference pulses.
- R4: When `tt_clear` is high, the count is 0 after the next clock edge. Clear has priority over load and step.
- R5: When `tt_load` is high and `tt_clear` is low, the count equals `tt_load_value` after the next edge. Load has priority over a step in the same clock.
- R6: When `tt_load` and `tt_load_keep_lsb` are both high, bit 0 of the count keeps its value from before the load. Bits 15:1 take the load value.
- R7: A high `msg_start` in a clock stores the count as it stood before that edge in `start_stamp`. That value is kept even when the same clock brings a step, clear or load. `start_stamp_valid` is high for exactly the following clock.
- R8: `msg_end` does the same for `end_stamp` and `end_stamp_valid`, independently of `msg_start`.
- R9: While reset is active, the count, both stamps and both valid strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | 1 MHz reference pulse, one clock wide |
| res_sel | input | 3 | Resolution select code |
| msg_start | input | 1 | Start-of-message strobe |
| msg_end | input | 1 | End-of-message strobe |
| tt_clear | input | 1 | Host clear of the count |
| tt_load | input | 1 | Host load of the count |
| tt_load_keep_lsb | input | 1 | Keep the current LSB during a load |
| tt_load_value | input | 16 | Host load value |
| tt_count | output | 16 | Live count |
| start_stamp | output | 16 | Count captured at message start |
| start_stamp_valid | output | 1 | One-cycle strobe for start_stamp |
| end_stamp | output | 16 | Count captured at message end |
| end_stamp_valid | output | 1 | One-cycle strobe for end_stamp |

## Verification
All results are due one clock after the stimulus. A step, clear or load that is sampled at an edge shows up on `tt_count` right after that edge, and a start or end strobe shows its stamp and valid pulse in the same cycle. The bench drives inputs on the falling edge. It advances a behavioural model at the rising edge from the inputs held then, and compares every output with the model at the next falling edge. Select changes, coinciding strobes and steps, masked loads and the wrap are therefore each checked in the exact cycle they take effect.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_RES = 6;
endpackage

// File: rtl/mtt_prescaler.sv
module mtt_prescaler #(
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned NUM_RES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] res_sel,
  output logic             step
);
  localparam int unsigned MAX_PER = 1 << NUM_RES;
  localparam int unsigned PRE_W   = $clog2(MAX_PER);

  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_q, pre_d, last;
  logic             sel_chg;

  function automatic logic [PRE_W-1:0] last_of(input logic [SEL_W-1:0] s);
    int unsigned per;
    if (int'(s) >= int'(NUM_RES) - 1) per = MAX_PER;
    else per = 2 << s;
    return PRE_W'(per - 1);
  endfunction

  always_comb begin
    sel_chg = (res_sel != sel_q);
    last    = last_of(res_sel);
    pre_d   = pre_q;
    step    = 1'b0;
    if (sel_chg) begin
      pre_d = '0;
    end else if (ref_tick) begin
      if (pre_q >= last) begin
        pre_d = '0;
        step  = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pre_q <= '0;
    end else begin
      sel_q <= res_sel;
      pre_q <= pre_d;
    end
  end

  assert_step_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ref_tick);
  assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
  assert_sel_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel != sel_q) |=> (pre_q == '0));
endmodule

// File: rtl/mtt_counter.sv
module mtt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic             ld_en,
  input  logic             ld_keep_lsb,
  input  logic [CNT_W-1:0] ld_value,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | ld_en | step;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (ld_en) begin
      cnt_d = {ld_value[CNT_W-1:1], ld_keep_lsb ? cnt_q[0] : ld_value[0]};
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !ld_en) |=> (count == CNT_W'($past(count) + 1'b1)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clr) |=> (count[CNT_W-1:1] == $past(ld_value[CNT_W-1:1])));
  assert_keep_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_keep_lsb && !clr) |=> (count[0] == $past(count[0])));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr && !ld_en) |=> $stable(count));
endmodule

// File: rtl/mtt_capture.sv
module mtt_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [CNT_W-1:0] src,
  output logic [CNT_W-1:0] stamp,
  output logic             vld
);
  logic [CNT_W-1:0] stamp_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stamp_q <= '0;
    else if (strobe) stamp_q <= src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else vld_q <= strobe;
  end

  assign stamp = stamp_q;
  assign vld   = vld_q;

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (vld && stamp == $past(src)));
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> (!vld && $stable(stamp)));
endmodule

// File: rtl/mtt_timetag.sv
module mtt_timetag
  import mtt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] res_sel,
  input  logic             msg_start,
  input  logic             msg_end,
  input  logic             tt_clear,
  input  logic             tt_load,
  input  logic             tt_load_keep_lsb,
  input  logic [CNT_W-1:0] tt_load_value,
  output logic [CNT_W-1:0] tt_count,
  output logic [CNT_W-1:0] start_stamp,
  output logic             start_stamp_valid,
  output logic [CNT_W-1:0] end_stamp,
  output logic             end_stamp_valid
);
  localparam int unsigned NUM_CH = 2;

  logic                  step;
  logic [CNT_W-1:0]      count;
  logic [NUM_CH-1:0]     ch_strobe;
  logic [CNT_W-1:0]      ch_stamp [NUM_CH];
  logic [NUM_CH-1:0]     ch_vld;

  mtt_prescaler #(.SEL_W(SEL_W), .NUM_RES(NUM_RES)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .res_sel(res_sel), .step(step)
  );

  mtt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(tt_clear), .ld_en(tt_load),
    .ld_keep_lsb(tt_load_keep_lsb), .ld_value(tt_load_value), .count(count)
  );

  assign ch_strobe = {msg_end, msg_start};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mtt_capture #(.CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .strobe(ch_strobe[g]), .src(count),
      .stamp(ch_stamp[g]), .vld(ch_vld[g])
    );
  end

  assign tt_count          = count;
  assign start_stamp       = ch_stamp[0];
  assign start_stamp_valid = ch_vld[0];
  assign end_stamp         = ch_stamp[1];
  assign end_stamp_valid   = ch_vld[1];

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (tt_count == '0 && !start_stamp_valid && !end_stamp_valid));
endmodule

// File: tb/mtt_timetag_bench.sv
module mtt_timetag_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [2:0]  res_sel = 3'd0;
  logic        msg_start = 1'b0, msg_end = 1'b0;
  logic        tt_clear = 1'b0, tt_load = 1'b0, tt_load_keep_lsb = 1'b0;
  logic [15:0] tt_load_value = 16'h0;
  logic [15:0] tt_count, start_stamp, end_stamp;
  logic        start_stamp_valid, end_stamp_valid;

  int total = 0, bad = 0, ncyc = 0;
  bit done = 0;
  string tag = "R1";

  int m_cnt = 0, m_pre = 0, m_selq = 0, m_ss = 0, m_es = 0;
  bit m_sv = 0, m_ev = 0;
  int wraps = 0;

  always #2.5 clk = ~clk;

  mtt_timetag u_mtt_timetag (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .res_sel(res_sel),
    .msg_start(msg_start), .msg_end(msg_end), .tt_clear(tt_clear),
    .tt_load(tt_load), .tt_load_keep_lsb(tt_load_keep_lsb),
    .tt_load_value(tt_load_value), .tt_count(tt_count),
    .start_stamp(start_stamp), .start_stamp_valid(start_stamp_valid),
    .end_stamp(end_stamp), .end_stamp_valid(end_stamp_valid)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int period(input int s);
    return (s >= 5) ? 64 : (2 << s);
  endfunction

  task automatic cyc();
    int old;
    bit st;
    @(posedge clk);
    old = m_cnt;
    st = 0;
    if (res_sel != m_selq) m_pre = 0;
    else if (ref_tick) begin
      if (m_pre + 1 >= period(res_sel)) begin m_pre = 0; st = 1; end
      else m_pre++;
    end
    m_selq = res_sel;
    if (tt_clear) m_cnt = 0;
    else if (tt_load) m_cnt = tt_tload(old);
    else if (st) begin m_cnt = (old + 1) & 16'hFFFF; if (m_cnt == 0) wraps++; end
    m_sv = msg_start; m_ev = msg_end;
    if (msg_start) m_ss = old;
    if (msg_end) m_es = old;
    @(negedge clk);
    ncyc++;
    check(tag, tt_count, m_cnt, "count");
    check("R7", start_stamp, m_ss, "start_stamp");
    check("R7", start_stamp_valid, m_sv, "start_valid");
    check("R8", end_stamp, m_es, "end_stamp");
    check("R8", end_stamp_valid, m_ev, "end_valid");
    ref_tick = (ncyc % 4 == 3);
  endtask

  function automatic int tt_tload(input int old);
    if (tt_load_keep_lsb) return (tt_load_value & 16'hFFFE) | (old & 1);
    return tt_load_value;
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", tt_count, 0, "reset count");
    check("R9", start_stamp_valid | end_stamp_valid, 0, "reset valids");
    check("R9", start_stamp | end_stamp, 0, "reset stamps");
    rst_n = 1'b1;

    for (int s = 0; s < 8; s++) begin
      tag = "R1";
      res_sel = 3'(s);
      run(period(s) * 4 * 3 + 10);
    end

    tag = "R3";
    res_sel = 3'd2; run(20);
    res_sel = 3'd1; run(3);
    res_sel = 3'd2; run(1);
    res_sel = 3'd0; run(40);

    tag = "R7";
    for (int k = 0; k < 24; k++) begin
      msg_start = (k % 3 == 0); msg_end = (k % 5 == 1);
      cyc();
    end
    msg_start = 1; msg_end = 1; run(9); msg_start = 0; msg_end = 0; run(4);

    tag = "R5";
    tt_load_value = 16'h1234; tt_load = 1; msg_start = 1; cyc();
    tt_load = 0; msg_start = 0; run(12);
    tt_load_value = 16'hABCD; tt_load = 1; run(8); tt_load = 0;

    tag = "R6";
    tt_load_keep_lsb = 1; tt_load = 1;
    tt_load_value = 16'h5550; cyc();
    tt_load_value = 16'h7771; cyc();
    tt_load = 0; run(9);
    tt_load = 1; tt_load_value = 16'h0F0E; cyc();
    tt_load = 0; tt_load_keep_lsb = 0; run(9);

    tag = "R4";
    tt_clear = 1; tt_load = 1; tt_load_value = 16'hFFFF; msg_end = 1; cyc();
    tt_clear = 0; tt_load = 0; msg_end = 0; run(10);
    tt_clear = 1; run(9); tt_clear = 0;

    tag = "R2";
    res_sel = 3'd0; run(2);
    tt_load_value = 16'hFFFE; tt_load = 1; cyc(); tt_load = 0;
    msg_end = 1; run(40); msg_end = 0;
    check("R2", wraps > 0, 1, "wrap seen");
    check("R2", tt_count < 16'h0010, 1, "count after wrap");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule